// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder/Subtractor

This block takes two IEEE 754 binary32 operands and produces their sum, or their difference when the subtract input is high. Subtraction is done by inverting the sign of the second operand. Both operands then follow one path.

The path has five steps. It orders the operands by magnitude and takes the exponent difference. It shifts the smaller significand right, keeping guard, round and sticky bits. It adds or subtracts the two significands. It normalizes the result, right by one on a carry or left by the leading-zero count on cancellation. It then rounds to nearest, ties to even.

A field of zero marks a denormal. A denormal takes part with scale 2^-126 and no hidden one, and can also be produced as a result. Zeros, infinities and NaNs are resolved beside the arithmetic. Overflow and underflow flags travel with every result. The block has two register stages and a valid bit that follows each operation.

Top module: `fp_addsub`

## Requirements
- R1: While rst_ni is low, and after it rises until the first accepted operation emerges, valid_o, result_o, ovf_o and unf_o are all zero.
- R2: An operation accepted with valid_i high on a rising edge appears with valid_o high exactly two rising edges later. Back-to-back operations are accepted on every cycle. A cycle with valid_i low yields a cycle with valid_o low two edges later.
- R3: For finite operands, result_o is a op b, where b's sign is inverted when sub_i is 1, rounded to nearest even. Result bit 31 is the sign, bits 30:23 the biased exponent and bits 22:0 the fraction. An exponent difference of 26 or more leaves only a sticky contribution from the smaller operand.
- R4: When the discarded part is exactly half an ulp, the result rounds to the even fraction. Above half it rounds up, and below half it rounds down.
- R5: A significand sum of 2 or more shifts right once and raises the exponent. A rounding carry out of the significand also raises the exponent.
- R6: An exact zero from operands of opposite effective sign is +0 (0x00000000). The sum of two zeros of equal effective sign keeps that sign.
- R7: An exponent field of 0 reads as 0.fraction x 2^-126. unf_o is 1 exactly when the result is nonzero with exponent field 0. A denormal sum that reaches 2^-126 becomes normal with unf_o 0.
- R8: A rounded result exponent of 255 or more gives a signed infinity (exponent field 0xFF, fraction 0) with ovf_o 1. ovf_o and unf_o are never both 1.
- R9: A NaN operand, or infinities of opposite effective sign, gives the quiet NaN 0x7FC00000 with both flags 0.
- R10: An infinity combined with a finite value, or with an infinity of the same effective sign, gives that infinity with both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| sub_i | input | 1 | 1: a minus b, 0: a plus b |
| a_i | input | 32 | First operand, binary32 |
| b_i | input | 32 | Second operand, binary32 |
| valid_o | output | 1 | Result present this cycle |
| result_o | output | 32 | Rounded binary32 result |
| ovf_o | output | 1 | Result overflowed to infinity |
| unf_o | output | 1 | Result is a nonzero denormal |

## Verification
The bench aims at exact halfway cases with odd and even fractions. A design that rounds half up, or drops the sticky OR, would leave the last fraction bit off by one.

It forces a rounding carry out of the largest finite value. A design that skips the exponent update after rounding would return a malformed maximum instead of infinity. Full cancellation and minus-zero pairs test the zero sign rule. Denormal pairs that sum across 2^-126 catch a normalizer that shifts past the minimum exponent or loses the hidden bit.

Infinity-minus-infinity and NaN inputs expose special-value paths that leak raw arithmetic or set flags. Random operands with nearby exponents and occasional equal magnitudes are compared on every clock against an exact wide-integer model.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;          // with hidden bit
  localparam int EXT_W  = SIG_W + 3;           // guard, round, sticky
  localparam int SUM_W  = EXT_W + 1;           // carry
  localparam int EXN_W  = EXP_W + 2;           // headroom for exponent adjust
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam logic [EXP_W-1:0]  EXP_MAX = '1;
  localparam logic [WORD_W-1:0] QNAN    = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              spec;
    logic [WORD_W-1:0] spec_res;
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [SUM_W-1:0]  sum;
  } fpa_mid_t;

  function automatic logic [LZ_W-1:0] lzc(input logic [EXT_W-1:0] v);
    int n;
    n = EXT_W;
    for (int i = 0; i < EXT_W; i++) if (v[i]) n = EXT_W - 1 - i;
    return n[LZ_W-1:0];
  endfunction
endpackage

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output fpa_mid_t          mid_o
);
  logic [WORD_W-1:0] w   [2];
  logic              sgn [2];
  logic [EXP_W-1:0]  ex  [2];
  logic [SIG_W-1:0]  sig [2];
  logic              inf [2];
  logic              nan [2];

  assign w[0] = a_i;
  assign w[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    assign e      = w[g][WORD_W-2:FRAC_W];
    assign f      = w[g][FRAC_W-1:0];
    assign sgn[g] = w[g][WORD_W-1] ^ ((g == 1) ? sub_i : 1'b0);
    assign ex[g]  = (e == '0) ? EXP_W'(1) : e;   // denormal scale
    assign sig[g] = {e != '0, f};
    assign inf[g] = (e == EXP_MAX) && (f == '0);
    assign nan[g] = (e == EXP_MAX) && (f != '0);
  end

  logic             swap, eff_sub, sign_l;
  logic [EXP_W-1:0] exp_l, exp_s, d;
  logic [EXT_W-1:0] ext_l, ext_s, mask, shifted, aligned;
  logic [SUM_W-1:0] sum;

  always_comb begin
    swap    = b_i[WORD_W-2:0] > a_i[WORD_W-2:0];
    eff_sub = sgn[0] ^ sgn[1];
    exp_l   = swap ? ex[1]  : ex[0];
    exp_s   = swap ? ex[0]  : ex[1];
    sign_l  = swap ? sgn[1] : sgn[0];
    ext_l   = {(swap ? sig[1] : sig[0]), 3'b000};
    ext_s   = {(swap ? sig[0] : sig[1]), 3'b000};
    d       = exp_l - exp_s;
    mask    = ~({EXT_W{1'b1}} << d);           // shift >= width gives full mask
    shifted = ext_s >> d;
    aligned = {shifted[EXT_W-1:1], shifted[0] | (|(ext_s & mask))};
    sum     = eff_sub ? ({1'b0, ext_l} - {1'b0, aligned})
                      : ({1'b0, ext_l} + {1'b0, aligned});

    mid_o.sign = (sum == '0 && eff_sub) ? 1'b0 : sign_l;
    mid_o.exp  = exp_l;
    mid_o.sum  = sum;
    mid_o.spec = inf[0] | inf[1] | nan[0] | nan[1];
    if (nan[0] || nan[1] || (inf[0] && inf[1] && eff_sub))
      mid_o.spec_res = QNAN;
    else
      mid_o.spec_res = {(inf[0] ? sgn[0] : sgn[1]), EXP_MAX, {FRAC_W{1'b0}}};
  end
endmodule

// File: rtl/fpa_normround.sv
module fpa_normround
  import fpa_pkg::*;
(
  input  fpa_mid_t          mid_i,
  output logic [WORD_W-1:0] res_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic [EXT_W-1:0] m;
  logic [EXN_W-1:0] e, lim, sh, lz;
  logic [SIG_W:0]   mant;
  logic             rnd_up;
  logic [EXP_W-1:0] fld;

  always_comb begin
    lz  = EXN_W'(lzc(mid_i.sum[EXT_W-1:0]));
    lim = EXN_W'(mid_i.exp) - EXN_W'(1);
    sh  = '0;
    if (mid_i.sum[SUM_W-1]) begin
      m = {mid_i.sum[SUM_W-1:2], |mid_i.sum[1:0]};
      e = EXN_W'(mid_i.exp) + EXN_W'(1);
    end else begin
      sh = (lz < lim) ? lz : lim;                  // stop at the denormal floor
      m  = mid_i.sum[EXT_W-1:0] << sh;
      e  = EXN_W'(mid_i.exp) - sh;
    end
    rnd_up = m[2] & (m[1] | m[0] | m[3]);
    mant   = {1'b0, m[EXT_W-1:3]} + (SIG_W+1)'(rnd_up);
    if (mant[SIG_W]) begin
      mant = mant >> 1;
      e    = e + EXN_W'(1);
    end
    fld   = mant[SIG_W-1] ? e[EXP_W-1:0] : '0;
    ovf_o = 1'b0;
    unf_o = 1'b0;
    if (mid_i.spec) begin
      res_o = mid_i.spec_res;
    end else if (e >= EXN_W'(EXP_MAX)) begin
      res_o = {mid_i.sign, EXP_MAX, {FRAC_W{1'b0}}};
      ovf_o = 1'b1;
    end else begin
      res_o = {mid_i.sign, fld, mant[FRAC_W-1:0]};
      unf_o = !mant[SIG_W-1] && (mant[FRAC_W-1:0] != '0);
    end
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fpa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sub_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o,
  output logic              ovf_o,
  output logic              unf_o
);
  fpa_mid_t          mid_d, mid_q;
  logic              s1_valid_q;
  logic [WORD_W-1:0] res_d;
  logic              ovf_d, unf_d;

  fpa_align u_align (.a_i(a_i), .b_i(b_i), .sub_i(sub_i), .mid_o(mid_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      mid_q      <= '0;
    end else begin
      s1_valid_q <= valid_i;
      if (valid_i) mid_q <= mid_d;
    end
  end

  fpa_normround u_norm (.mid_i(mid_q), .res_o(res_d), .ovf_o(ovf_d), .unf_o(unf_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
      unf_o    <= 1'b0;
    end else begin
      valid_o <= s1_valid_q;
      if (s1_valid_q) begin
        result_o <= res_d;
        ovf_o    <= ovf_d;
        unf_o    <= unf_d;
      end
    end
  end
endmodule

// File: rtl/fpa_chk.sv
module fpa_chk
  import fpa_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s1_valid_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] result_o,
  input logic              ovf_o,
  input logic              unf_o
);
  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni) s1_valid_i |=> valid_o); // R2
  AST_IDLE_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni) !s1_valid_i |=> !valid_o); // R2
  AST_OVF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> result_o[WORD_W-2:0] == {EXP_MAX, {FRAC_W{1'b0}}}); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(ovf_o && unf_o)); // R8
  AST_UNF_DENORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (result_o[WORD_W-2:FRAC_W] == '0) && (result_o[FRAC_W-1:0] != '0)); // R7
  AST_NAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && result_o[WORD_W-2:FRAC_W] == EXP_MAX && result_o[FRAC_W-1:0] != '0)
      |-> (result_o == QNAN && !ovf_o && !unf_o)); // R9
endmodule

bind fp_addsub fpa_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s1_valid_i (s1_valid_q),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o)
);

// File: tb/sim_fp_addsub.sv
`timescale 1ns/1ps
module sim_fp_addsub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, sub_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o, ovf_o, unf_o;
  logic [31:0] result_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  logic [33:0] q_exp[$];
  int          q_due[$];
  string       q_tag[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  fp_addsub u0 (.clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sub_i(sub_i),
                .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o),
                .ovf_o(ovf_o), .unf_o(unf_o));

  // value in units of 2^-149
  function automatic logic [299:0] mag(input logic [31:0] x);
    logic [299:0] s;
    int e;
    e = (x[30:23] == 0) ? 1 : int'(x[30:23]);
    s = {276'd0, (x[30:23] != 0), x[22:0]};
    return s << (e - 1);
  endfunction

  // returns {ovf, unf, result}
  function automatic logic [33:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic sa, sb, sr, na, nb, ia, ib;
    logic [299:0] ma, mb, m, mant, rem, half;
    int p, sh, fld;
    sa = a[31]; sb = b[31] ^ s;
    na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    ia = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    ib = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    if (na || nb || (ia && ib && sa != sb)) return {2'b00, 32'h7FC00000};
    if (ia) return {2'b00, sa, 8'hFF, 23'd0};
    if (ib) return {2'b00, sb, 8'hFF, 23'd0};
    ma = mag(a); mb = mag(b);
    if (sa == sb) begin m = ma + mb; sr = sa; end
    else if (ma >= mb) begin m = ma - mb; sr = (ma == mb) ? 1'b0 : sa; end
    else begin m = mb - ma; sr = sb; end
    p = -1;
    for (int i = 0; i < 300; i++) if (m[i]) p = i;
    if (p <= 23) return {1'b0, (p >= 0 && p < 23), sr, m[30:0]};
    sh   = p - 23;
    mant = m >> sh;
    rem  = m & ((300'd1 << sh) - 300'd1);
    half = 300'd1 << (sh - 1);
    if (rem > half || (rem == half && mant[0])) mant = mant + 300'd1;
    if (mant[24]) begin mant = mant >> 1; sh++; end
    fld = sh + 1;
    if (fld >= 255) return {2'b10, sr, 8'hFF, 23'd0};
    return {2'b00, sr, fld[7:0], mant[22:0]};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s, input string tag);
    @(negedge clk);
    a_i = a; b_i = b; sub_i = s; valid_i = 1'b1;
    q_exp.push_back(ref_add(a, b, s));
    q_due.push_back(cyc + 2);
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // per-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        logic [33:0] exp_v;
        string tg;
        exp_v = q_exp.pop_front();
        tg = q_tag.pop_front();
        void'(q_due.pop_front());
        if (!valid_o || {ovf_o, unf_o, result_o} != exp_v) begin
          n_fail++;
          $display("FAIL %s/R2: valid=%0b {ovf,unf,res}=%h expected valid=1 %h",
                   tg, valid_o, {ovf_o, unf_o, result_o}, exp_v);
        end
      end else if (valid_o) begin
        n_fail++;
        $display("FAIL R2: valid_o=1 expected 0 at cycle %0d", cyc);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0 || result_o !== 32'd0 || ovf_o !== 1'b0 || unf_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: outputs %b %h %b %b expected 0 0 0 0", valid_o, result_o, ovf_o, unf_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0 || result_o !== 32'd0) begin
      n_fail++;
      $display("FAIL R1: after release %b %h expected 0 0", valid_o, result_o);
    end
    send(32'h3F800000, 32'h3F800000, 1'b0, "R3");
    send(32'h3FC00000, 32'h3E800000, 1'b1, "R3");
    send(32'h3F800000, 32'h30800000, 1'b0, "R3");
    send(32'h3F800000, 32'h33800000, 1'b0, "R4");
    send(32'h3F800001, 32'h33800000, 1'b0, "R4");
    send(32'h3F800000, 32'h33800001, 1'b0, "R4");
    idle();
    send(32'h3FC00000, 32'h3FC00000, 1'b0, "R5");
    send(32'h3FFFFFFF, 32'h33800000, 1'b0, "R5");
    send(32'h3F800001, 32'h3F800000, 1'b1, "R6");
    send(32'h3F800000, 32'h3F800000, 1'b1, "R6");
    send(32'hBF800000, 32'h3F800000, 1'b0, "R6");
    send(32'h80000000, 32'h80000000, 1'b0, "R6");
    send(32'h80000000, 32'h00000000, 1'b1, "R6");
    idle(); idle();
    send(32'h00000001, 32'h00000001, 1'b0, "R7");
    send(32'h00800000, 32'h00000001, 1'b1, "R7");
    send(32'h00400000, 32'h00400000, 1'b0, "R7");
    send(32'h80000003, 32'h00000001, 1'b0, "R7");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R8");
    send(32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, "R8");
    send(32'h7F7FFFFF, 32'h73000000, 1'b0, "R8");
    send(32'h7F800000, 32'h7F800000, 1'b1, "R9");
    send(32'h7FC00001, 32'h3F800000, 1'b0, "R9");
    send(32'hFF800000, 32'h7F800000, 1'b0, "R9");
    send(32'h7F800000, 32'h3F800000, 1'b0, "R10");
    send(32'h3F800000, 32'h7F800000, 1'b1, "R10");
    send(32'hFF800000, 32'hFF800000, 1'b0, "R10");
    for (int i = 0; i < 800; i++) begin
      logic [31:0] r, a, b;
      r = $urandom; a = $urandom; b = $urandom;
      if (r[1:0] != 2'b00) b[30:23] = a[30:23] ^ {3'b000, r[6:2]};
      if (r[14:12] == 3'b000) begin
        b[30:0] = a[30:0];
        send(a, {~(a[31] ^ r[8]), b[30:0]}, r[8], "R6");
      end else begin
        send(a, b, r[8], "R3");
      end
      if (r[11:9] == 3'b000) idle();
    end
    idle();
    while (q_due.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule